// File: doc/BRIEF.md
# Warp Issue Scheduler with Operand Scoreboard

This block sits between the per-warp instruction buffers and a SIMD datapath of a multithreaded streaming core. Every resident warp offers one pending instruction together with two source register tags, a destination register tag and a static priority level. Each cycle that the datapath can accept work, the block picks one warp whose operands are ready and sends that warp's instruction, tagged with its warp number, to the datapath. Switching from one warp to another costs no extra cycle.

Readiness comes from a scoreboard that holds one pending-write flag per warp per architectural register. Issuing an instruction raises the flag for its destination. A writeback completion naming a warp and a register drops that flag. A warp is eligible only when none of its three tagged registers is still awaiting a write. Among eligible warps the highest priority level wins. Ties go round-robin, starting just past the warp that issued last.

One instruction for a whole warp occupies the datapath for a fixed number of cycles, so the block stays quiet for that window after every issue. A small control machine with two states handles this. In ST_SELECT it issues on any cycle with an eligible warp. It then moves to ST_DISPATCH, or stays in ST_SELECT when the window is one cycle. ST_DISPATCH counts out the rest of the window and returns to ST_SELECT when the count reaches zero. With the default window of 4, a 32-thread warp runs on 8 lanes. `NUM_REGS` must be a power of two.

Top module: `warp_issue_sched`

## Requirements
- R1: A synchronous active-low reset clears every pending flag, drops issue_valid and places the round-robin pointer on the highest-numbered warp, so warp 0 is considered first. The reset holds while rst_n is low at a rising edge.
- R2: A warp is eligible only when its warp_valid bit is 1 and its pending flags are clear for src_a, src_b and dst. Each warp's tags sit in bit field [w*TAG_W +: TAG_W] of the tag vectors.
- R3: The issue edge sets the pending flag of (issued warp, its dst). A writeback with wb_valid high clears only the flag of (wb_warp, wb_reg) at that edge, and no other warp's flag. The warp counts as ready from the following edge; a writeback has no same-cycle bypass.
- R4: Among eligible warps, the one with the numerically largest warp_prio level issues. Warp w's level sits in bits [w*PRIO_W +: PRIO_W].
- R5: Among eligible warps sharing the top level, the first found when scanning upward from the last issued warp plus one, wrapping around, issues.
- R6: An issue is registered. issue_valid is high for exactly one cycle after the chosen edge, and issue_warp and issue_instr carry the winner's number and its warp_instr field [w*INSTR_W +: INSTR_W].
- R7: After an issue edge no issue occurs on the next DISPATCH_CYCLES-1 edges (state ST_DISPATCH). An eligible warp issues on the DISPATCH_CYCLES-th edge (state ST_SELECT), so back-to-back issues are exactly DISPATCH_CYCLES cycles apart.
- R8: An edge in ST_SELECT with no eligible warp yields an idle slot with issue_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| warp_valid | input | NUM_WARPS | Per-warp flag that an instruction is offered |
| warp_prio | input | NUM_WARPS*PRIO_W | Per-warp priority level, larger wins |
| warp_src_a | input | NUM_WARPS*TAG_W | Per-warp first source register tag |
| warp_src_b | input | NUM_WARPS*TAG_W | Per-warp second source register tag |
| warp_dst | input | NUM_WARPS*TAG_W | Per-warp destination register tag |
| warp_instr | input | NUM_WARPS*INSTR_W | Per-warp instruction word |
| wb_valid | input | 1 | Writeback completion strobe |
| wb_warp | input | WARP_W | Warp of the completed write |
| wb_reg | input | TAG_W | Register of the completed write |
| issue_valid | output | 1 | Issue slot carries an instruction |
| issue_warp | output | WARP_W | Number of the issued warp |
| issue_instr | output | INSTR_W | Issued instruction word |

## Verification
The hardest situation to reach from the ports is a warp that is blocked only by its own earlier write. The release also has to come out in the right cycle: one edge after the matching writeback, and not through a writeback to the same register of another warp. The bench gets there by keeping an instruction offered after it issued, then turning it into a read of the pending register. It sends a writeback to a different warp before the matching one. The round-robin pointer is walked through every position by sweeping all valid masks twice under several priority patterns, and a free-running phase acts as the execution unit to expose the dispatch spacing.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

    typedef enum logic {
        ST_SELECT   = 1'b0,
        ST_DISPATCH = 1'b1
    } disp_state_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wsched_scoreboard.sv
module wsched_scoreboard #(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 16,
    parameter int WARP_W    = 5,
    parameter int TAG_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_en,
    input  logic [WARP_W-1:0]          set_warp,
    input  logic [TAG_W-1:0]           set_reg,
    input  logic                       clr_en,
    input  logic [WARP_W-1:0]          clr_warp,
    input  logic [TAG_W-1:0]           clr_reg,
    input  logic [NUM_WARPS-1:0]       req_valid,
    input  logic [NUM_WARPS*TAG_W-1:0] src_a,
    input  logic [NUM_WARPS*TAG_W-1:0] src_b,
    input  logic [NUM_WARPS*TAG_W-1:0] dst,
    output logic [NUM_WARPS-1:0]       ready
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [NUM_REGS-1:0] pend;
        logic [NUM_REGS-1:0] set_mask;
        logic [NUM_REGS-1:0] clr_mask;
        logic [TAG_W-1:0]    tag_a;
        logic [TAG_W-1:0]    tag_b;
        logic [TAG_W-1:0]    tag_d;

        assign tag_a = src_a[w*TAG_W +: TAG_W];
        assign tag_b = src_b[w*TAG_W +: TAG_W];
        assign tag_d = dst[w*TAG_W +: TAG_W];

        // A new issue claims a register; a completion releases one.
        always_comb begin
            set_mask = '0;
            clr_mask = '0;
            if (set_en && (set_warp == WARP_W'(w))) begin
                set_mask = NUM_REGS'(1) << set_reg;
            end
            if (clr_en && (clr_warp == WARP_W'(w))) begin
                clr_mask = NUM_REGS'(1) << clr_reg;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend <= '0;
            end else begin
                pend <= (pend & ~clr_mask) | set_mask;
            end
        end

        // Read-after-write on both sources and write-after-write on dst.
        always_comb begin
            ready[w] = req_valid[w]
                     & ~pend[tag_a]
                     & ~pend[tag_b]
                     & ~pend[tag_d];
        end
    end

endmodule

// File: rtl/wsched_arbiter.sv
module wsched_arbiter #(
    parameter int NUM_WARPS = 24,
    parameter int PRIO_W    = 2,
    parameter int WARP_W    = 5
) (
    input  logic [NUM_WARPS-1:0]        ready,
    input  logic [NUM_WARPS*PRIO_W-1:0] prio,
    input  logic [WARP_W-1:0]           last_warp,
    output logic                        any_ready,
    output logic [WARP_W-1:0]           winner
);

    logic [PRIO_W-1:0]    top_level;
    logic [NUM_WARPS-1:0] cand;

    // Stage 1: highest level present among ready warps.
    always_comb begin
        top_level = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (ready[w] && (prio[w*PRIO_W +: PRIO_W] > top_level)) begin
                top_level = prio[w*PRIO_W +: PRIO_W];
            end
        end
    end

    // Stage 2: keep only ready warps on that level.
    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            cand[w] = ready[w] && (prio[w*PRIO_W +: PRIO_W] == top_level);
        end
    end

    // Stage 3: rotating scan that starts just past the last issuer.
    always_comb begin
        logic found;
        found  = 1'b0;
        winner = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            int j;
            j = int'(last_warp) + k;
            if (j >= NUM_WARPS) begin
                j = j - NUM_WARPS;
            end
            if (!found && cand[j]) begin
                winner = WARP_W'(j);
                found  = 1'b1;
            end
        end
        any_ready = found;
    end

endmodule

// File: rtl/wsched_dispatch_fsm.sv
module wsched_dispatch_fsm #(
    parameter int DISPATCH_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_ready,
    output logic grant
);

    import wsched_pkg::*;

    localparam int CNT_W = idx_width(DISPATCH_CYCLES);

    disp_state_t state;
    disp_state_t state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_SELECT: begin
                if (any_ready && (DISPATCH_CYCLES > 1)) begin
                    state_nx = ST_DISPATCH;
                    cnt_nx   = CNT_W'(DISPATCH_CYCLES - 2);
                end
            end
            ST_DISPATCH: begin
                if (cnt == '0) begin
                    state_nx = ST_SELECT;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SELECT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Outputs: an issue happens only from the selecting state.
    always_comb begin
        grant = (state == ST_SELECT) && any_ready;
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
    parameter int NUM_WARPS       = 24,
    parameter int NUM_REGS        = 16,
    parameter int PRIO_W          = 2,
    parameter int INSTR_W         = 32,
    parameter int DISPATCH_CYCLES = 4,
    localparam int WARP_W         = wsched_pkg::idx_width(NUM_WARPS),
    localparam int TAG_W          = wsched_pkg::idx_width(NUM_REGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WARPS-1:0]         warp_valid,
    input  logic [NUM_WARPS*PRIO_W-1:0]  warp_prio,
    input  logic [NUM_WARPS*TAG_W-1:0]   warp_src_a,
    input  logic [NUM_WARPS*TAG_W-1:0]   warp_src_b,
    input  logic [NUM_WARPS*TAG_W-1:0]   warp_dst,
    input  logic [NUM_WARPS*INSTR_W-1:0] warp_instr,
    input  logic                         wb_valid,
    input  logic [WARP_W-1:0]            wb_warp,
    input  logic [TAG_W-1:0]             wb_reg,
    output logic                         issue_valid,
    output logic [WARP_W-1:0]            issue_warp,
    output logic [INSTR_W-1:0]           issue_instr
);

    logic [NUM_WARPS-1:0] ready;
    logic                 any_ready;
    logic [WARP_W-1:0]    winner;
    logic                 grant;
    logic [WARP_W-1:0]    last_warp;
    logic [TAG_W-1:0]     win_dst;

    assign win_dst = warp_dst[winner*TAG_W +: TAG_W];

    wsched_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_REGS  (NUM_REGS),
        .WARP_W    (WARP_W),
        .TAG_W     (TAG_W)
    ) u_scoreboard (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (grant),
        .set_warp  (winner),
        .set_reg   (win_dst),
        .clr_en    (wb_valid),
        .clr_warp  (wb_warp),
        .clr_reg   (wb_reg),
        .req_valid (warp_valid),
        .src_a     (warp_src_a),
        .src_b     (warp_src_b),
        .dst       (warp_dst),
        .ready     (ready)
    );

    wsched_arbiter #(
        .NUM_WARPS (NUM_WARPS),
        .PRIO_W    (PRIO_W),
        .WARP_W    (WARP_W)
    ) u_arbiter (
        .ready     (ready),
        .prio      (warp_prio),
        .last_warp (last_warp),
        .any_ready (any_ready),
        .winner    (winner)
    );

    wsched_dispatch_fsm #(
        .DISPATCH_CYCLES (DISPATCH_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_ready (any_ready),
        .grant     (grant)
    );

    // Registered issue slot and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_instr <= '0;
            last_warp   <= WARP_W'(NUM_WARPS - 1);
        end else begin
            issue_valid <= grant;
            if (grant) begin
                issue_warp  <= winner;
                issue_instr <= warp_instr[winner*INSTR_W +: INSTR_W];
                last_warp   <= winner;
            end
        end
    end

endmodule

// File: rtl/wsched_checker.sv
module wsched_checker #(
    parameter int NUM_WARPS       = 24,
    parameter int DISPATCH_CYCLES = 4,
    parameter int WARP_W          = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WARPS-1:0] warp_valid,
    input logic                 issue_valid,
    input logic [WARP_W-1:0]    issue_warp
);

    logic [NUM_WARPS-1:0] valid_q;
    logic [31:0]          since;

    always_ff @(posedge clk) begin
        valid_q <= warp_valid;
        if (!rst_n) begin
            since <= 32'(DISPATCH_CYCLES);
        end else if (issue_valid) begin
            since <= 32'd1;
        end else if (since < 32'(DISPATCH_CYCLES)) begin
            since <= since + 32'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !issue_valid) else $error("reset left an issue"); // R1

    AST_FROM_OFFERED: assert property (@(posedge clk) disable iff (!rst_n) issue_valid |-> valid_q[issue_warp]) else $error("issued warp was not offered"); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (issue_valid && (DISPATCH_CYCLES > 1)) |=> !issue_valid) else $error("issue longer than one cycle"); // R6

    AST_WINDOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n) issue_valid |-> (since >= 32'(DISPATCH_CYCLES))) else $error("dispatch window cut short"); // R7

    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (valid_q == '0) |-> !issue_valid) else $error("issue with nothing offered"); // R8

endmodule

bind warp_issue_sched wsched_checker #(
    .NUM_WARPS       (NUM_WARPS),
    .DISPATCH_CYCLES (DISPATCH_CYCLES),
    .WARP_W          (WARP_W)
) u_wsched_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .warp_valid  (warp_valid),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp)
);

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;

    localparam int NW = 4;
    localparam int NR = 4;
    localparam int PW = 2;
    localparam int IW = 16;
    localparam int DC = 4;
    localparam int WW = 2;
    localparam int RW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [NW-1:0]     warp_valid = '0;
    logic [NW*PW-1:0]  warp_prio = '0;
    logic [NW*RW-1:0]  warp_src_a = '0;
    logic [NW*RW-1:0]  warp_src_b = '0;
    logic [NW*RW-1:0]  warp_dst = '0;
    logic [NW*IW-1:0]  warp_instr = '0;
    logic              wb_valid = 1'b0;
    logic [WW-1:0]     wb_warp = '0;
    logic [RW-1:0]     wb_reg = '0;
    logic              issue_valid;
    logic [WW-1:0]     issue_warp;
    logic [IW-1:0]     issue_instr;

    warp_issue_sched #(
        .NUM_WARPS(NW), .NUM_REGS(NR), .PRIO_W(PW),
        .INSTR_W(IW), .DISPATCH_CYCLES(DC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_prio(warp_prio),
        .warp_src_a(warp_src_a), .warp_src_b(warp_src_b), .warp_dst(warp_dst),
        .warp_instr(warp_instr), .wb_valid(wb_valid), .wb_warp(wb_warp),
        .wb_reg(wb_reg), .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_instr(issue_instr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int last_w = NW - 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int instr_of(input int w, input int tag);
        return (w * 256) + tag;
    endfunction

    task automatic cfg(input int w, input int sa, input int sb, input int d,
                       input int p, input int tag);
        warp_src_a[w*RW +: RW] = RW'(sa);
        warp_src_b[w*RW +: RW] = RW'(sb);
        warp_dst[w*RW +: RW]   = RW'(d);
        warp_prio[w*PW +: PW]  = PW'(p);
        warp_instr[w*IW +: IW] = IW'(instr_of(w, tag));
    endtask

    function automatic int prio_pat(input int pat, input int w);
        case (pat)
            0:       return 0;
            1:       return w;
            2:       return NW - 1 - w;
            default: return (w % 2) * 3;
        endcase
    endfunction

    // Expected winner from R4/R5 for a set of eligible warps.
    function automatic int model(input int mask);
        int top;
        top = -1;
        for (int w = 0; w < NW; w++) begin
            if (mask[w] && (int'(warp_prio[w*PW +: PW]) > top)) top = int'(warp_prio[w*PW +: PW]);
        end
        for (int k = 1; k <= NW; k++) begin
            int j;
            j = (last_w + k) % NW;
            if (mask[j] && (int'(warp_prio[j*PW +: PW]) == top)) return j;
        end
        return -1;
    endfunction

    // Offer a mask for one edge from an idle, clean state; act as the execution unit.
    task automatic trial(input int mask, input int tag);
        int e;
        e = model(mask);
        @(negedge clk);
        warp_valid = NW'(mask);
        @(negedge clk);
        warp_valid = '0;
        chk(issue_valid == (e >= 0), "R2,R8 issue_valid", int'(issue_valid), int'(e >= 0));
        if (e >= 0) begin
            chk(int'(issue_warp) == e, "R4,R5 winner", int'(issue_warp), e);
            chk(int'(issue_instr) == instr_of(e, tag), "R6 instr", int'(issue_instr), instr_of(e, tag));
            wb_valid = 1'b1;
            wb_warp  = WW'(e);
            wb_reg   = RW'(e);
            last_w   = e;
        end
        @(negedge clk);
        wb_valid = 1'b0;
        repeat (DC) @(negedge clk);
    endtask

    // First issue seen within n cycles, -1 if none.
    task automatic watch(input int n, output int w);
        w = -1;
        repeat (n) begin
            @(negedge clk);
            if (issue_valid && (w < 0)) w = int'(issue_warp);
        end
    endtask

    task automatic pulse_wb(input int w, input int r);
        @(negedge clk);
        wb_valid = 1'b1;
        wb_warp  = WW'(w);
        wb_reg   = RW'(r);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int w;
        int prev_c;
        int prev_w;
        int c;
        int n_iss;
        for (int i = 0; i < NW; i++) cfg(i, i, i, i, 0, 0);

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk(issue_valid == 1'b0, "R1 reset quiet", int'(issue_valid), 0);
        end
        rst_n = 1'b1;

        // R1: pointer starts so that warp 0 wins among equals
        trial(15, 0);

        // R4 R5 R8: sweep every mask twice under each priority pattern
        for (int pat = 0; pat < 4; pat++) begin
            for (int i = 0; i < NW; i++) cfg(i, i, i, i, prio_pat(pat, i), pat + 1);
            for (int m = 0; m < (1 << NW); m++) begin
                trial(m, pat + 1);
                trial(m, pat + 1);
            end
        end

        // R7 R5: free-running issue with immediate writebacks
        for (int i = 0; i < NW; i++) cfg(i, i, i, i, 0, 9);
        prev_c = -1;
        prev_w = last_w;
        c = 0;
        n_iss = 0;
        @(negedge clk);
        warp_valid = '1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            c++;
            wb_valid = 1'b0;
            if (issue_valid) begin
                n_iss++;
                chk(int'(issue_warp) == (prev_w + 1) % NW, "R5 rotation", int'(issue_warp), (prev_w + 1) % NW);
                if (prev_c >= 0) chk((c - prev_c) == DC, "R7 spacing", c - prev_c, DC);
                prev_c   = c;
                prev_w   = int'(issue_warp);
                wb_valid = 1'b1;
                wb_warp  = issue_warp;
                wb_reg   = RW'(issue_warp);
            end
        end
        warp_valid = '0;
        @(negedge clk);
        wb_valid = 1'b0;
        chk(n_iss == 40 / DC, "R7 issue count", n_iss, 40 / DC);
        last_w = prev_w;
        repeat (DC + 2) @(negedge clk);

        // R2 R3: self-blocking through the scoreboard
        cfg(0, 1, 1, 2, 0, 1);
        warp_valid = 4'b0001;
        @(negedge clk);
        chk(issue_valid && (issue_warp == 0), "R2 first issue", int'(issue_valid), 1);
        watch(10, w);
        chk(w == -1, "R2 dst still pending", w, -1);
        cfg(0, 2, 1, 3, 0, 2);
        watch(10, w);
        chk(w == -1, "R2 src_a pending", w, -1);
        pulse_wb(1, 2);
        chk(issue_valid == 1'b0, "R3 other warp wb", int'(issue_valid), 0);
        watch(6, w);
        chk(w == -1, "R3 other warp wb ignored", w, -1);
        pulse_wb(0, 2);
        chk(issue_valid == 1'b0, "R3 no bypass", int'(issue_valid), 0);
        @(negedge clk);
        chk(issue_valid && (issue_warp == 0), "R3 release next edge", int'(issue_valid), 1);
        chk(int'(issue_instr) == instr_of(0, 2), "R3 new instr", int'(issue_instr), instr_of(0, 2));
        warp_valid = '0;
        pulse_wb(0, 3);
        last_w = 0;
        repeat (DC + 2) @(negedge clk);

        // R2 R3: src_b block on warp 1, warp 2 proceeds meanwhile
        cfg(1, 0, 0, 1, 0, 4);
        warp_valid = 4'b0010;
        @(negedge clk);
        chk(issue_valid && (issue_warp == 1), "R2 warp1 issue", int'(issue_warp), 1);
        cfg(1, 0, 1, 0, 0, 5);
        cfg(2, 2, 2, 2, 0, 6);
        warp_valid = 4'b0110;
        watch(8, w);
        chk(w == 2, "R2 src_b blocks warp1", w, 2);
        warp_valid = 4'b0010;
        pulse_wb(2, 2);
        pulse_wb(1, 1);
        watch(8, w);
        chk(w == 1, "R3 warp1 released", w, 1);
        warp_valid = '0;
        pulse_wb(1, 0);
        repeat (DC + 2) @(negedge clk);

        // R1: reset mid-flight clears pending flags and pointer
        for (int i = 0; i < NW; i++) cfg(i, i, i, i, 0, 7);
        warp_valid = 4'b0100;
        watch(6, w);
        chk(w == 2, "R1 pre-reset issue", w, 2);
        rst_n = 1'b0;
        warp_valid = 4'b1111;
        @(negedge clk);
        chk(issue_valid == 1'b0, "R1 quiet in reset", int'(issue_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(issue_valid == 1'b1, "R1 pending cleared", int'(issue_valid), 1);
        chk(int'(issue_warp) == 0, "R1 pointer reset", int'(issue_warp), 0);
        warp_valid = '0;
        repeat (DC + 2) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule